// File: doc/BRIEF.md
# Sensor Acquisition Trigger Scheduler

This block decides when a group of sensor interfaces starts a new acquisition, and it ties each start to a PWM carrier. Each cycle it takes a peak pulse and a valley pulse from the carrier generator. A mode input selects which of these pulses count as events. A ratio input sets how many counted events make up one trigger period. When a period ends, the block issues a single-cycle trigger, but only if every sensor has reported completion of its previous acquisition. If any sensor is still busy, that period is dropped and no trigger is issued. The block does not delay the trigger to a later cycle.

For each sensor the block keeps a done flag. A trigger clears the flag, and that sensor's completion pulse sets it again. The block ANDs the flags into an all-done flag and pulses an interrupt when that flag rises. A shared elapsed-time counter restarts on every trigger. When a sensor's flag rises, the block copies the counter into that sensor's time register, which gives its acquisition latency. A fast sensor therefore waits for the slowest sensor in the group and is never started again while another sensor is still working.

Top module: `acq_trigger_sched`

## Requirements
- R1: The mode input selects the counted carrier events: 2'b00 counts peak pulses only, 2'b01 counts valley pulses only, and 2'b10 or 2'b11 counts both.
- R2: The event counter advances by one for each counted event. In the cycle after the counter equals the active ratio, the counter is back at zero, whether or not a trigger is issued. An event in that match cycle is not counted.
- R3: The trigger output is high for exactly one cycle. It is high in the cycle after a match cycle during which the all-done flag was high, and it is high in no other cycle.
- R4: A ratio input of 0 acts as 1. The active ratio loads from the input only while the counter is zero, so a change made during a period takes effect from the next period.
- R5: Each done flag is 1 after reset. A trigger clears it, and that sensor's completion pulse sets it again. When both occur in the same cycle, the trigger wins.
- R6: The all-done flag is the AND of all done flags. At most one trigger occurs in each interval during which all-done is high, so no sensor is triggered again while any sensor is busy.
- R7: The interrupt is a one-cycle pulse in the first cycle that all-done is high after being low. Reset never produces an interrupt.
- R8: The time counter is zero in the cycle after a trigger and then counts up by one each cycle, stopping at its maximum value. If a sensor's completion pulse arrives k cycles after the trigger cycle while its flag is low, that sensor's time register becomes k-1, limited to the maximum. A pulse that arrives while the flag is already high leaves the time register unchanged.
- R9: While reset is asserted, the trigger and the interrupt are 0, all done flags and the all-done flag are 1, and all time registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| peak_i | input | 1 | Carrier peak pulse |
| valley_i | input | 1 | Carrier valley pulse |
| mode_i | input | 2 | Selects which carrier events are counted |
| ratio_i | input | RW | Number of counted events in one trigger period |
| sensor_done_i | input | N | Completion pulse from each sensor |
| trig_o | output | 1 | Single-cycle acquisition trigger |
| done_o | output | N | Done flag for each sensor |
| all_done_o | output | 1 | AND of all done flags |
| irq_o | output | 1 | Pulse on the rising edge of all-done |
| acq_time_o | output | N*TW | Captured latency for each sensor; sensor i occupies bits [i*TW +: TW] |

## Verification
Suppose the event counter or the active ratio holds a wrong value. The trigger then appears one or more carrier events early or late, and a trace of the trigger port shows this as soon as the period ends. Suppose a done flag is stuck or is cleared wrongly. The bench then sees a trigger while a slow sensor is still busy, or sees a trigger that never comes, within one carrier period. It also sees an interrupt count that differs from the trigger count once the bench stops. A wrong elapsed counter shows up in the time register at the next completion. The bench compares every output against its own expected value on every cycle, so each of these faults is caught at the cycle where it first reaches a port.

// File: rtl/acq_trigger_sched.sv
module acq_trigger_sched #(
  parameter int N  = 2,
  parameter int RW = 8,
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            peak_i,
  input  logic            valley_i,
  input  logic [1:0]      mode_i,
  input  logic [RW-1:0]   ratio_i,
  input  logic [N-1:0]    sensor_done_i,
  output logic            trig_o,
  output logic [N-1:0]    done_o,
  output logic            all_done_o,
  output logic            irq_o,
  output logic [N*TW-1:0] acq_time_o
);

  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [RW-1:0] ONE  = RW'(1);

  logic          evt, match, trig_q, ad_q;
  logic [RW-1:0] cnt_q, ratio_q;
  logic [TW-1:0] tmr_q;
  logic [N-1:0]  done_q;
  logic [TW-1:0] time_q [N];

  assign evt   = mode_i[1] ? (peak_i | valley_i) : (mode_i[0] ? valley_i : peak_i);
  assign match = (cnt_q == ratio_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= ONE;
      trig_q  <= 1'b0;
      ad_q    <= 1'b1;
      tmr_q   <= '0;
    end else begin
      if (cnt_q == '0) ratio_q <= (ratio_i == '0) ? ONE : ratio_i;
      if (match)    cnt_q <= '0;
      else if (evt) cnt_q <= cnt_q + ONE;
      trig_q <= match & all_done_o;
      ad_q   <= all_done_o;
      if (trig_q)             tmr_q <= '0;
      else if (tmr_q != TMAX) tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '1;
      for (int i = 0; i < N; i++) time_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (trig_q) done_q[i] <= 1'b0;
        else if (sensor_done_i[i]) begin
          done_q[i] <= 1'b1;
          if (!done_q[i]) time_q[i] <= tmr_q;
        end
      end
    end
  end

  assign trig_o     = trig_q;
  assign done_o     = done_q;
  assign all_done_o = &done_q;
  assign irq_o      = all_done_o & ~ad_q;

  for (genvar g = 0; g < N; g++) begin : g_time
    assign acq_time_o[g*TW +: TW] = time_q[g];
  end

  AST_TRIG_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) trig_o |=> !trig_o); // R3
  AST_TRIG_QUAL:    assert property (@(posedge clk) disable iff (!rst_n) trig_o |-> $past(all_done_o)); // R3
  AST_TRIG_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) trig_o |=> (done_o == '0)); // R5
  AST_ONE_PER_DONE: assert property (@(posedge clk) disable iff (!rst_n) trig_o |-> all_done_o); // R6
  AST_IRQ_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) irq_o |=> !irq_o); // R7
  AST_IRQ_HIGH:     assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> all_done_o); // R7
  AST_CNT_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= ratio_q); // R2
  AST_RATIO_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (cnt_q != '0) |=> $stable(ratio_q)); // R4
  AST_RATIO_NZ:     assert property (@(posedge clk) disable iff (!rst_n) ratio_q != '0); // R4

endmodule

// File: tb/test_acq_trigger_sched.sv
module test_acq_trigger_sched;
  localparam int N = 2, RW = 4, TW = 8;

  logic clk = 0, rst_n = 0, peak = 0, valley = 0;
  logic [1:0] mode = 2'b10;
  logic [RW-1:0] ratio = 1;
  logic [N-1:0] sdone = '0;
  logic trig, all_done, irq;
  logic [N-1:0] done;
  logic [N*TW-1:0] atime;

  acq_trigger_sched #(.N(N), .RW(RW), .TW(TW)) i_acq_trigger_sched (
    .clk(clk), .rst_n(rst_n), .peak_i(peak), .valley_i(valley), .mode_i(mode),
    .ratio_i(ratio), .sensor_done_i(sdone), .trig_o(trig), .done_o(done),
    .all_done_o(all_done), .irq_o(irq), .acq_time_o(atime));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, trig_cnt = 0, irq_cnt = 0, last_trig = -1000, min_gap = 100000, cyc = 0;
  bit finished = 0, model_chk = 0, rnd = 0;
  int lat [N];
  int rem [N];

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // reference expectations
  logic [RW-1:0] m_cnt, m_ratio;
  logic m_trig, m_adp;
  logic [TW-1:0] m_tmr;
  logic [N-1:0] m_done;
  logic [TW-1:0] m_time [N];

  function automatic logic counted(logic p, logic v, logic [1:0] md);
    if (md == 2'b00) return p;
    if (md == 2'b01) return v;
    return p | v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_ratio <= 1; m_trig <= 0; m_adp <= 1; m_tmr <= 0; m_done <= '1;
      for (int i = 0; i < N; i++) m_time[i] <= 0;
    end else begin
      if (m_cnt == 0) m_ratio <= (ratio == 0) ? RW'(1) : ratio;
      if (m_cnt == m_ratio) m_cnt <= 0;
      else if (counted(peak, valley, mode)) m_cnt <= m_cnt + 1;
      m_trig <= (m_cnt == m_ratio) && (&m_done);
      m_adp <= &m_done;
      m_tmr <= m_trig ? '0 : (m_tmr == '1 ? m_tmr : m_tmr + 1);
      for (int i = 0; i < N; i++) begin
        if (m_trig) m_done[i] <= 0;
        else if (sdone[i]) begin
          m_done[i] <= 1;
          if (!m_done[i]) m_time[i] <= m_tmr;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && model_chk) begin
      chk("R3 trigger", trig, m_trig);
      chk("R5 done flags", done, m_done);
      chk("R6 all_done", all_done, &m_done);
      chk("R7 irq", irq, (&m_done) & ~m_adp);
      for (int i = 0; i < N; i++) chk("R8 time", atime[i*TW +: TW], m_time[i]);
    end
    if (rst_n && trig) begin
      trig_cnt++;
      if (cyc - last_trig < min_gap) min_gap = cyc - last_trig;
      last_trig = cyc;
    end
    if (rst_n && irq) irq_cnt++;
  end

  // sensor responders
  always @(negedge clk) begin
    logic [N-1:0] sd;
    sd = '0;
    for (int i = 0; i < N; i++) begin
      if (rst_n && trig) rem[i] = rnd ? 1 + int'($urandom % 60) : lat[i];
      else if (rem[i] > 0) begin
        rem[i]--;
        if (rem[i] == 0) sd[i] = 1;
      end else if (rnd && ($urandom % 50 == 0)) sd[i] = 1;
    end
    sdone = sd;
  end

  task automatic ev(logic p, logic v);
    @(negedge clk); peak = p; valley = v;
    @(negedge clk); peak = 0; valley = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin rem[i] = 0; lat[i] = 1; end
    repeat (4) @(negedge clk);
    chk("R9 reset trig", trig, 0);
    chk("R9 reset done", done, 2'b11);
    chk("R9 reset all_done", all_done, 1);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset time", atime, 0);
    rst_n = 1; model_chk = 1;
    repeat (3) @(negedge clk);
    chk("R7 no irq after reset", irq_cnt, 0);

    // R6: fast and slow sensor, ratio 1, both edges
    lat[0] = 3; lat[1] = 40; mode = 2'b10; ratio = 1;
    for (int k = 0; k < 40; k++) ev(k % 2 == 0, k % 2 == 1);
    repeat (60) @(negedge clk);
    chk("R6 triggers occurred", trig_cnt > 5, 1);
    chk("R6 min trigger spacing", min_gap >= 42, 1);
    chk("R8 fast latency", atime[0 +: TW], 2);
    chk("R8 slow latency", atime[TW +: TW], 39);
    chk("R7 irq per acquisition", irq_cnt, trig_cnt);

    // R1: mode selection
    lat[0] = 1; lat[1] = 1;
    begin
      int t0;
      mode = 2'b00; t0 = trig_cnt;
      repeat (4) ev(0, 1);
      chk("R1 peak mode ignores valley", trig_cnt - t0, 0);
      t0 = trig_cnt; repeat (4) ev(1, 0);
      chk("R1 peak mode counts peak", trig_cnt - t0, 4);
      mode = 2'b01; t0 = trig_cnt; repeat (3) ev(1, 0);
      chk("R1 valley mode ignores peak", trig_cnt - t0, 0);
      t0 = trig_cnt; repeat (3) ev(0, 1);
      chk("R1 valley mode counts valley", trig_cnt - t0, 3);
      mode = 2'b11; t0 = trig_cnt; repeat (2) ev(1, 0); repeat (2) ev(0, 1);
      chk("R1 both mode", trig_cnt - t0, 4);

      // R4: ratio 0 and mid-period change
      mode = 2'b10; ratio = 0; t0 = trig_cnt; repeat (3) ev(1, 0);
      chk("R4 ratio zero acts as one", trig_cnt - t0, 3);
      ratio = 3; repeat (3) @(negedge clk);
      t0 = trig_cnt; ev(1, 0);
      ratio = 1; ev(1, 0);
      chk("R4 mid-period write held", trig_cnt - t0, 0);
      ev(0, 1);
      chk("R2 ratio three period", trig_cnt - t0, 1);
      ev(1, 0);
      chk("R4 new ratio next period", trig_cnt - t0, 2);

      // R8: saturation
      lat[0] = 2; lat[1] = 300; t0 = trig_cnt;
      ev(1, 0);
      repeat (320) @(negedge clk);
      chk("R8 saturated time", atime[TW +: TW], 255);
      chk("R8 short time", atime[0 +: TW], 1);
    end

    // random phase
    rnd = 1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      peak = ($urandom % 8 == 0);
      valley = ($urandom % 8 == 0);
      if ($urandom % 100 == 0) mode = 2'($urandom);
      if ($urandom % 100 == 0) ratio = RW'($urandom % 4);
    end
    peak = 0; valley = 0; rnd = 0;
    repeat (100) @(negedge clk);
    chk("R7 irq count equals trigger count", irq_cnt, trig_cnt);
    summary();
  end

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule